// File: doc/BRIEF.md
# LED Driver Startup Sequencer

This block is the digital power-up and enable controller of a single-string boost LED driver. The analog comparators, the current sink and the boost loop sit outside it and appear as digital flags. When the supply is good and the enable/dimming pin is high, the sequencer precharges the LED pin. It waits until the LED pin has charged and the output-sense pin is above its short-circuit level. It then runs a soft start with reduced sink gain and a constant source into the compensation node. When the string reaches full current, it hands over to normal regulation.

In normal operation the enable pin also carries the PWM dimming signal. A short low turns the boost and the sink off and floats the compensation node, while the references stay powered. The next high resumes regulation at once. A low that lasts for the shutdown timeout turns everything off and pulses a fault-clear strobe. The next high then repeats the whole startup check. A supply drop is acted on only after a deglitch window, and an accepted drop also clears faults. All timing is counted in system clock cycles.

Top module: `led_startup_seq`

## Requirements
- R1: After reset, and while the supply flag has never been seen high or the synchronized enable is low, every output is low (off state). The block leaves the off state only when both the supply flag and the enable are high.
- R2: On leaving the off state the block enters precharge (ref_en_o=1, precharge_o=1, every other output 0). It stays there for as long as led_chg_i is low.
- R3: While vout_ok_i is low the block stays in precharge even when led_chg_i is high. Soft start begins on the first clock edge at which led_chg_i and vout_ok_i are both high.
- R4: In soft start, ss_mode_o, comp_src_o, boost_en_o, sink_en_o and ref_en_o are 1. The block moves to regulation (ref_en_o, boost_en_o, sink_en_o high; ss_mode_o, comp_src_o low) on the first edge at which led_reg_i is high.
- R5: A low enable during regulation gives the dim state: boost_en_o=0, sink_en_o=0, comp_hiz_o=1, ref_en_o=1. A high enable in the dim state returns straight to regulation, with no precharge or soft start.
- R6: If the synchronized enable stays low for LOW_OFF_CYC cycles in the dim state, the block goes to the off state and raises fault_clr_o for exactly one cycle. The next high enable restarts at precharge.
- R7: A low supply flag is ignored unless it lasts UVLO_DGL_CYC consecutive cycles. A low of that length sends the block to the off state from any state and raises fault_clr_o for one cycle.
- R8: Once entered, regulation lasts at least MIN_ON_CYC cycles before a low enable can move the block to the dim state, so a shorter enable pulse is stretched.
- R9: A low enable during precharge or soft start returns the block to the off state at once, without a fault-clear pulse.
- R10: The enable passes through SYNC_STAGES flops, 2 by default. A change on en_pwm_i therefore first shows on the outputs after the third rising clock edge.
- R11: When an accepted supply drop falls in the same cycle as any other transition, the supply drop wins and the block goes to the off state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vin_ok_i | input | 1 | Supply above the UVLO level |
| en_pwm_i | input | 1 | Enable / PWM dimming pin, asynchronous |
| led_chg_i | input | 1 | LED pin above its precharge level |
| vout_ok_i | input | 1 | Output-sense pin above its undervoltage level |
| led_reg_i | input | 1 | LED string at full preset current |
| ref_en_o | output | 1 | Internal references powered |
| precharge_o | output | 1 | LED pin precharge source on |
| ss_mode_o | output | 1 | Sink uses the reduced soft-start gain |
| comp_src_o | output | 1 | Constant current source into the compensation node |
| boost_en_o | output | 1 | Boost converter switching allowed |
| sink_en_o | output | 1 | LED current sink on |
| comp_hiz_o | output | 1 | Compensation node floated |
| fault_clr_o | output | 1 | One-cycle strobe that clears latched faults |

## Verification
The supply deglitch and the dim-state wake can fall in the same cycle. The bench takes the block to the dim state and drops the supply flag. One cycle later it raises the enable, so the deglitch window runs out on the same edge at which the synchronized enable would wake the block. The pass condition is the off state with boost and sink low, and it must hold for several cycles afterwards. Around this case, randomized dimming pulses with sub-window supply glitches check that short supply dips never disturb regulation or dimming.

// File: rtl/led_seq_pkg.sv
package led_seq_pkg;
   typedef enum logic [2:0] {
      ST_OFF    = 3'd0,
      ST_PRECHG = 3'd1,
      ST_SOFT   = 3'd2,
      ST_RUN    = 3'd3,
      ST_DIM    = 3'd4
   } seq_state_e;
endpackage

// File: rtl/led_seq_sync.sv
module led_seq_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("led_seq_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] ff_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ff_q <= '0;
      else        ff_q <= {ff_q[STAGES-2:0], d_i};
   end

   assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/led_seq_uvlo.sv
module led_seq_uvlo #(
   parameter int DGL_CYC = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic vin_ok_i,
   output logic vin_good_o,
   output logic trip_o
);
   localparam int CW = $clog2(DGL_CYC + 1);
   localparam logic [CW-1:0] LAST = CW'(DGL_CYC - 1);

   logic [CW-1:0] low_cnt_q;
   logic          good_q;

   assign trip_o     = !vin_ok_i && good_q && (low_cnt_q == LAST);
   assign vin_good_o = good_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_cnt_q <= '0;
         good_q    <= 1'b0;
      end else if (vin_ok_i) begin
         low_cnt_q <= '0;
         good_q    <= 1'b1;
      end else begin
         if (low_cnt_q != LAST) low_cnt_q <= low_cnt_q + CW'(1);
         if (trip_o)            good_q    <= 1'b0;
      end
   end
endmodule

// File: rtl/led_seq_lowtimer.sv
module led_seq_lowtimer #(
   parameter int LOW_CYC = 160000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_s_i,
   output logic expired_o
);
   localparam int CW = $clog2(LOW_CYC + 1);
   localparam logic [CW-1:0] LIMIT = CW'(LOW_CYC);

   logic [CW-1:0] cnt_q;

   assign expired_o = (cnt_q == LIMIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt_q <= '0;
      else if (en_s_i)     cnt_q <= '0;
      else if (!expired_o) cnt_q <= cnt_q + CW'(1);
   end
endmodule

// File: rtl/led_startup_seq.sv
module led_startup_seq
   import led_seq_pkg::*;
#(
   parameter int SYNC_STAGES  = 2,
   parameter int LOW_OFF_CYC  = 160000,
   parameter int UVLO_DGL_CYC = 10,
   parameter int MIN_ON_CYC   = 30
) (
   input  logic clk,
   input  logic rst_n,
   input  logic vin_ok_i,
   input  logic en_pwm_i,
   input  logic led_chg_i,
   input  logic vout_ok_i,
   input  logic led_reg_i,
   output logic ref_en_o,
   output logic precharge_o,
   output logic ss_mode_o,
   output logic comp_src_o,
   output logic boost_en_o,
   output logic sink_en_o,
   output logic comp_hiz_o,
   output logic fault_clr_o
);
   localparam int OW = $clog2(MIN_ON_CYC + 1);
   localparam logic [OW-1:0] ON_LOAD = OW'(MIN_ON_CYC - 1);

   generate
      if (UVLO_DGL_CYC < 2) begin : g_bad_dgl
         $error("led_startup_seq: UVLO_DGL_CYC must be at least 2");
      end
      if (MIN_ON_CYC < 1) begin : g_bad_minon
         $error("led_startup_seq: MIN_ON_CYC must be at least 1");
      end
      if (LOW_OFF_CYC <= MIN_ON_CYC) begin : g_bad_low
         $error("led_startup_seq: LOW_OFF_CYC must exceed MIN_ON_CYC");
      end
   endgenerate

   logic en_s, vin_good, uvlo_trip, low_expired;

   led_seq_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst_n(rst_n), .d_i(en_pwm_i), .q_o(en_s));

   led_seq_uvlo #(.DGL_CYC(UVLO_DGL_CYC)) uvlo_i (
      .clk(clk), .rst_n(rst_n), .vin_ok_i(vin_ok_i),
      .vin_good_o(vin_good), .trip_o(uvlo_trip));

   led_seq_lowtimer #(.LOW_CYC(LOW_OFF_CYC)) lowtmr_i (
      .clk(clk), .rst_n(rst_n), .en_s_i(en_s), .expired_o(low_expired));

   seq_state_e    st_q, st_d;
   logic [OW-1:0] on_cnt_q;
   logic          clr_q;

   always_comb begin
      st_d = st_q;
      if (uvlo_trip) begin
         st_d = ST_OFF;
      end else begin
         unique case (st_q)
            ST_OFF:    if (vin_good && en_s) st_d = ST_PRECHG;
            ST_PRECHG: if (!en_s) st_d = ST_OFF;
                       else if (led_chg_i && vout_ok_i) st_d = ST_SOFT;
            ST_SOFT:   if (!en_s) st_d = ST_OFF;
                       else if (led_reg_i) st_d = ST_RUN;
            ST_RUN:    if (!en_s && on_cnt_q == '0) st_d = ST_DIM;
            ST_DIM:    if (en_s) st_d = ST_RUN;
                       else if (low_expired) st_d = ST_OFF;
            default:   st_d = ST_OFF;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_OFF;
         on_cnt_q <= '0;
         clr_q    <= 1'b0;
      end else begin
         st_q  <= st_d;
         clr_q <= uvlo_trip || (st_q == ST_DIM && !en_s && low_expired);
         if (st_d == ST_RUN && st_q != ST_RUN)  on_cnt_q <= ON_LOAD;
         else if (st_q == ST_RUN && on_cnt_q != '0) on_cnt_q <= on_cnt_q - OW'(1);
      end
   end

   always_comb begin
      ref_en_o    = (st_q != ST_OFF);
      precharge_o = (st_q == ST_PRECHG);
      ss_mode_o   = (st_q == ST_SOFT);
      comp_src_o  = (st_q == ST_SOFT);
      boost_en_o  = (st_q == ST_SOFT) || (st_q == ST_RUN);
      sink_en_o   = (st_q == ST_SOFT) || (st_q == ST_RUN);
      comp_hiz_o  = (st_q == ST_DIM);
   end

   assign fault_clr_o = clr_q;
endmodule

// File: rtl/led_seq_chk.sv
module led_seq_chk #(
   parameter int MIN_ON_CYC = 30
) (
   input logic clk,
   input logic rst_n,
   input logic led_chg_i,
   input logic vout_ok_i,
   input logic led_reg_i,
   input logic ref_en_o,
   input logic precharge_o,
   input logic ss_mode_o,
   input logic comp_src_o,
   input logic boost_en_o,
   input logic sink_en_o,
   input logic comp_hiz_o,
   input logic fault_clr_o
);
   localparam int RW = $clog2(MIN_ON_CYC + 1);

   logic          run;
   logic [RW-1:0] run_cnt_q;

   assign run = boost_en_o && !ss_mode_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      run_cnt_q <= '0;
      else if (!run)                   run_cnt_q <= '0;
      else if (run_cnt_q != RW'(MIN_ON_CYC)) run_cnt_q <= run_cnt_q + RW'(1);
   end

   p_prechg_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ref_en_o) |-> (precharge_o && !boost_en_o));

   p_soft_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ss_mode_o) |-> ($past(led_chg_i) && $past(vout_ok_i)));

   p_soft_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ss_mode_o |-> (comp_src_o && sink_en_o && !comp_hiz_o));

   p_run_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(ss_mode_o) && boost_en_o) |-> $past(led_reg_i));

   p_dim_outputs_r5: assert property (@(posedge clk) disable iff (!rst_n)
      comp_hiz_o |-> (!boost_en_o && !sink_en_o && ref_en_o));

   p_clear_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
      fault_clr_o |-> !ref_en_o);

   p_min_on_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(run) && comp_hiz_o) |-> (run_cnt_q == RW'(MIN_ON_CYC)));
endmodule

bind led_startup_seq led_seq_chk #(.MIN_ON_CYC(MIN_ON_CYC)) chk_i (
   .clk(clk), .rst_n(rst_n), .led_chg_i(led_chg_i), .vout_ok_i(vout_ok_i),
   .led_reg_i(led_reg_i), .ref_en_o(ref_en_o), .precharge_o(precharge_o),
   .ss_mode_o(ss_mode_o), .comp_src_o(comp_src_o), .boost_en_o(boost_en_o),
   .sink_en_o(sink_en_o), .comp_hiz_o(comp_hiz_o), .fault_clr_o(fault_clr_o));

// File: tb/led_startup_seq_tb.sv
`timescale 1ns/1ps
module led_startup_seq_tb_top;
   localparam int LOWC = 40;
   localparam int DGLC = 4;
   localparam int MONC = 6;

   localparam logic [6:0] M_OFF  = 7'b0000000;
   localparam logic [6:0] M_PRE  = 7'b1100000;
   localparam logic [6:0] M_SOFT = 7'b1011110;
   localparam logic [6:0] M_RUN  = 7'b1000110;
   localparam logic [6:0] M_DIM  = 7'b1000001;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic vin_ok = 1'b0, en = 1'b0, led_chg = 1'b0, vout_ok = 1'b0, led_reg = 1'b0;
   logic ref_en, prechg, ss, csrc, boost, sink, chiz, fclr;
   int   checks = 0, fails = 0, clr_cnt = 0;
   bit   done = 1'b0;

   always #2 clk = ~clk;

   led_startup_seq #(.LOW_OFF_CYC(LOWC), .UVLO_DGL_CYC(DGLC), .MIN_ON_CYC(MONC)) dut_i (
      .clk(clk), .rst_n(rst_n), .vin_ok_i(vin_ok), .en_pwm_i(en),
      .led_chg_i(led_chg), .vout_ok_i(vout_ok), .led_reg_i(led_reg),
      .ref_en_o(ref_en), .precharge_o(prechg), .ss_mode_o(ss),
      .comp_src_o(csrc), .boost_en_o(boost), .sink_en_o(sink),
      .comp_hiz_o(chiz), .fault_clr_o(fclr));

   always @(negedge clk) if (fclr) clr_cnt++;

   function automatic logic [6:0] outs();
      return {ref_en, prechg, ss, csrc, boost, sink, chiz};
   endfunction

   task automatic step(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(string req, logic [6:0] exp);
      checks++;
      if (outs() !== exp) begin
         fails++;
         $display("FAIL %s actual=%b expected=%b", req, outs(), exp);
      end
   endtask

   task automatic chk_int(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
   end

   initial begin
      int c0;
      void'($urandom(32'd2024));
      step(3);
      chk("R1 reset", M_OFF);
      rst_n = 1'b1;
      vin_ok = 1'b1; step(5);
      chk("R1 supply only", M_OFF);
      // R10: latency of the enable path
      en = 1'b1; step(2);
      chk("R10 two edges", M_OFF);
      step(1);
      chk("R10 R2 precharge", M_PRE);
      vout_ok = 1'b1; step(10);
      chk("R2 led pin held low", M_PRE);
      led_chg = 1'b1; vout_ok = 1'b0; step(10);
      chk("R3 output short", M_PRE);
      vout_ok = 1'b1; step(1);
      chk("R3 R4 soft start", M_SOFT);
      step(5);
      chk("R4 waits for regulation", M_SOFT);
      led_reg = 1'b1; step(1);
      chk("R4 run", M_RUN);
      step(MONC + 2);
      en = 1'b0; step(3);
      chk("R5 dim", M_DIM);
      en = 1'b1; step(3);
      chk("R5 resume", M_RUN);
      step(MONC + 2);
      en = 1'b0; step(3);
      // R8: one-cycle pulse stretched to MIN_ON
      en = 1'b1; step(1); en = 1'b0; step(3);
      chk("R8 stretched", M_RUN);
      step(MONC + 2);
      chk("R8 back to dim", M_DIM);
      en = 1'b1; step(MONC + 4);
      // R6: long low
      c0 = clr_cnt;
      en = 1'b0; step(LOWC + 1);
      chk("R6 still dim", M_DIM);
      step(3);
      chk("R6 shutdown", M_OFF);
      step(1);
      chk_int("R6 clear pulse", clr_cnt - c0, 1);
      en = 1'b1; step(3);
      chk("R6 restart precharge", M_PRE);
      step(MONC + 4);
      chk("R6 regulation", M_RUN);
      // R9
      en = 1'b0; step(LOWC + 8);
      led_chg = 1'b0; c0 = clr_cnt;
      en = 1'b1; step(3);
      chk("R9 precharge", M_PRE);
      en = 1'b0; step(3);
      chk("R9 abort", M_OFF);
      step(1);
      chk_int("R9 no clear", clr_cnt - c0, 0);
      // R7
      led_chg = 1'b1; en = 1'b1; step(MONC + 10);
      chk("R7 run", M_RUN);
      vin_ok = 1'b0; step(DGLC - 1); vin_ok = 1'b1; step(2);
      chk("R7 glitch ignored", M_RUN);
      c0 = clr_cnt;
      vin_ok = 1'b0; step(DGLC);
      chk("R7 trip", M_OFF);
      step(1);
      chk_int("R7 clear pulse", clr_cnt - c0, 1);
      vin_ok = 1'b1; step(MONC + 10);
      chk("R7 recovered", M_RUN);
      // R11: supply trip coincides with wake from dim
      en = 1'b0; step(5);
      chk("R11 dim", M_DIM);
      vin_ok = 1'b0; step(1);
      en = 1'b1; step(3);
      chk("R11 trip wins", M_OFF);
      step(5);
      chk("R11 stays off", M_OFF);
      vin_ok = 1'b1; step(MONC + 10);
      // random dimming with sub-window supply glitches
      for (int i = 0; i < 30; i++) begin
         int hi_len, lo_len, g;
         hi_len = MONC + 3 + int'($urandom % 10);
         lo_len = 4 + int'($urandom % (LOWC - 14));
         g = 1 + int'($urandom % (DGLC - 1));
         en = 1'b1; step(3);
         chk("R5 random high", M_RUN);
         vin_ok = 1'b0; step(g); vin_ok = 1'b1;
         step(hi_len - 3 - g + 1);
         chk("R7 random glitch", M_RUN);
         en = 1'b0; step(3);
         chk("R5 random low", M_DIM);
         step(lo_len - 3);
      end
      summary();
   end
endmodule